// File: doc/BRIEF.md
# Interlocked Three-Line Byte Handshake Engine

This block moves bytes across a shared parallel bus using a fully interlocked handshake built from three control lines: an active-low data-valid line, plus ready-for-data and data-accepted lines. The ready and accepted lines are wired-AND, so each is high only when every active receiver releases it. Because no step has a fixed duration, every transfer runs at the pace of the slowest receiver taking part. The same engine serves as either side of a transfer. As a sender, it takes a byte from a local valid/ready port and carries it through the handshake. As a receiver, it captures bus bytes and presents each one with a single-cycle strobe.

Mode inputs decide which side is active. Talker mode enables the sending side. Listener mode, or the bus being in address mode, enables the receiving side. Talker mode takes priority over both. A device with neither side active releases both wired-AND lines so it cannot stall a transfer between other devices. A bus-wide abort line, active low, returns both sides to idle. Every bus input is resynchronised before the state machines use it, so the bus may be driven from any clock domain.

Line drivers are modelled as separate in/out/enable signals: a released open-collector line is an output of 1. Address decoding is done outside this block.

Top module: `byte_handshake_engine`

## Requirements
- R1: After reset, with all modes off, the block holds data-valid released (1), ready-for-data and data-accepted released (1), the data enable at 0, tx_ready at 0 and rx_strobe at 0.
- R2: In talker mode with the sending side idle and abort high, tx_ready is 1. A byte offered with tx_valid is taken on that edge. The byte appears on the data outputs with the enable at 1 while data-valid is still released.
- R3: The sender drives data-valid low only after it has seen ready-for-data high and data-accepted low on the bus.
- R4: The sender holds data-valid low until it sees data-accepted high, then returns data-valid high. It keeps the data enabled and unchanged until it sees data-accepted low again, so the data enable never falls while data-valid is low.
- R5: A receiver waiting for a byte outputs ready-for-data 1 and data-accepted 0. On seeing data-valid low, it captures the data, pulses rx_strobe for exactly one cycle with rx_data holding the byte, and outputs ready-for-data 0 and data-accepted 1.
- R6: The receiver keeps data-accepted high while data-valid stays low. Once data-valid is back high, it outputs data-accepted 0 and ready-for-data 1.
- R7: With several receivers of different speeds on the wired-AND lines, every receiver gets each byte, and data-valid never falls while the combined ready-for-data line is low.
- R8: While address mode is 1, the receiving side is active even if listener mode is 0.
- R9: When listener mode and address mode are both 0, or talker mode is 1, the block holds its ready-for-data and data-accepted outputs at 1 through other devices' transfers and gives no rx_strobe.
- R10: Three clock edges after the abort line goes low, the sender has data-valid released and the data enable at 0, and the receiver has both wired-AND outputs at 1.
- R11: Each bus input passes through SYNC_STAGES flops (default 2). A data-valid fall is first answered by rx_strobe SYNC_STAGES+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| talk_mode | input | 1 | Enables the sending side; overrides receiving |
| listen_mode | input | 1 | Device addressed as a receiver |
| addr_mode | input | 1 | Bus in address mode; every device receives |
| bus_abort_n | input | 1 | Bus abort line, low forces both sides idle |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Sender can take a byte |
| rx_data | output | DATA_W | Last captured byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_data is updated |
| bus_data_in | input | DATA_W | Data lines as seen on the bus |
| bus_data_out | output | DATA_W | Data driven by the sender |
| bus_data_oe | output | 1 | Data driver enable |
| bus_dav_n_in | input | 1 | Data-valid line, active low |
| bus_dav_n_out | output | 1 | Data-valid drive, 1 = released |
| bus_rfd_in | input | 1 | Wired-AND ready-for-data line |
| bus_rfd_out | output | 1 | Ready-for-data drive, 1 = released/ready |
| bus_dac_in | input | 1 | Wired-AND data-accepted line |
| bus_dac_out | output | 1 | Data-accepted drive, 1 = released/accepted |

## Verification
A bus input change takes SYNC_STAGES edges to reach the state machines, plus one edge for the state register. The strobe and wired-AND outputs follow the state register, so by default each answer to a line change appears three edges after the change. The bench drives at falling edges and samples at falling edges. At fixed latencies, such as the strobe after a data-valid fall and the idle outputs after an abort, it counts the exact rising edges before checking. The open-ended handshake steps it polls with bounded loops. Ordering rules on the shared lines, such as data-valid falling only with ready-for-data high and the data staying stable until released, are watched every cycle by a monitor whose violation counts are checked at the end.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

   typedef enum logic [1:0] {
      SRC_IDLE     = 2'd0,
      SRC_WAIT_RFD = 2'd1,
      SRC_DAV_LOW  = 2'd2,
      SRC_DAV_HIGH = 2'd3
   } src_state_e;

   typedef enum logic [1:0] {
      ACC_OFF   = 2'd0,
      ACC_READY = 2'd1,
      ACC_HOLD  = 2'd2
   } acc_state_e;

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/hs_source.sv
`timescale 1ns/1ps
module hs_source
   import hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              abort_ni,
   input  logic              rfd_i,
   input  logic              dac_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o,
   output logic              dav_n_o
);

   src_state_e        st_q, st_d;
   logic [DATA_W-1:0] byte_q;
   logic              go;
   logic              take;

   assign go   = enable_i && abort_ni;
   assign take = (st_q == SRC_IDLE) && go && tx_valid_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         SRC_IDLE:     if (take)              st_d = SRC_WAIT_RFD;
         SRC_WAIT_RFD: if (rfd_i && !dac_i)   st_d = SRC_DAV_LOW;
         SRC_DAV_LOW:  if (dac_i)             st_d = SRC_DAV_HIGH;
         SRC_DAV_HIGH: if (!dac_i)            st_d = SRC_IDLE;
         default:                             st_d = SRC_IDLE;
      endcase
      if (!go) st_d = SRC_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SRC_IDLE;
         byte_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) byte_q <= tx_data_i;
      end
   end

   assign tx_ready_o = (st_q == SRC_IDLE) && go;
   assign data_o     = byte_q;
   assign data_oe_o  = (st_q != SRC_IDLE);
   assign dav_n_o    = (st_q != SRC_DAV_LOW);

   // R2: a valid strobe on the bus always has the byte driven
   assert_dav_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dav_n_o |-> data_oe_o);

   // R4: driven byte does not change until released
   assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

   // R4: outside an abort, data is released only after data-valid is back high
   assert_release_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(data_oe_o) && $past(abort_ni) && $past(enable_i)) |-> $past(dav_n_o));

   // R3: data-valid only falls after the bus showed ready
   assert_dav_after_rfd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dav_n_o) |-> $past(rfd_i && !dac_i));

   // R10: abort returns the sender to idle on the next edge
   assert_abort_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_ni |=> (dav_n_o && !data_oe_o));

endmodule

// File: rtl/hs_acceptor.sv
`timescale 1ns/1ps
module hs_acceptor
   import hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              abort_ni,
   input  logic              dav_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              rfd_o,
   output logic              dac_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_strobe_o
);

   acc_state_e st_q, st_d;
   logic       act;
   logic       grab;

   assign act  = active_i && abort_ni;
   assign grab = act && (st_q == ACC_READY) && !dav_n_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ACC_OFF:   if (act)     st_d = ACC_READY;
         ACC_READY: if (grab)    st_d = ACC_HOLD;
         ACC_HOLD:  if (dav_n_i) st_d = ACC_READY;
         default:                st_d = ACC_OFF;
      endcase
      if (!act) st_d = ACC_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ACC_OFF;
         rx_data_o   <= '0;
         rx_strobe_o <= 1'b0;
      end else begin
         st_q        <= st_d;
         rx_strobe_o <= grab;
         if (grab) rx_data_o <= data_i;
      end
   end

   assign rfd_o = (st_q == ACC_OFF) || (st_q == ACC_READY);
   assign dac_o = (st_q == ACC_OFF) || (st_q == ACC_HOLD);

   // R9: an inactive receiver releases both wired-AND lines
   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> (rfd_o && dac_o));

   // R5: strobe coincides with accepted-high and ready-low
   assert_strobe_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe_o |-> (dac_o && !rfd_o));

   // R6: accepted stays high while data-valid is still low
   assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_o && !rfd_o && active_i && abort_ni && !dav_n_i) |=> dac_o);

   // R10: abort releases the receiver lines on the next edge
   assert_abort_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_ni |=> (rfd_o && dac_o && !rx_strobe_o));

endmodule

// File: rtl/byte_handshake_engine.sv
`timescale 1ns/1ps
module byte_handshake_engine #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              talk_mode,
   input  logic              listen_mode,
   input  logic              addr_mode,
   input  logic              bus_abort_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_strobe,
   input  logic [DATA_W-1:0] bus_data_in,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   input  logic              bus_dav_n_in,
   output logic              bus_dav_n_out,
   input  logic              bus_rfd_in,
   output logic              bus_rfd_out,
   input  logic              bus_dac_in,
   output logic              bus_dac_out
);

   localparam int SYNC_W = DATA_W + 4;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, 1'b0, {DATA_W{1'b0}}};

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic              abort_s, dav_n_s, rfd_s, dac_s;
   logic [DATA_W-1:0] data_s;
   logic              rx_active;

   assign raw_in = {bus_abort_n, bus_dav_n_in, bus_rfd_in, bus_dac_in, bus_data_in};

   hs_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign {abort_s, dav_n_s, rfd_s, dac_s, data_s} = sync_out;

   assign rx_active = (listen_mode || addr_mode) && !talk_mode;

   hs_source #(.DATA_W(DATA_W)) u_source (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (talk_mode),
      .abort_ni   (abort_s),
      .rfd_i      (rfd_s),
      .dac_i      (dac_s),
      .tx_data_i  (tx_data),
      .tx_valid_i (tx_valid),
      .tx_ready_o (tx_ready),
      .data_o     (bus_data_out),
      .data_oe_o  (bus_data_oe),
      .dav_n_o    (bus_dav_n_out)
   );

   hs_acceptor #(.DATA_W(DATA_W)) u_acceptor (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (rx_active),
      .abort_ni    (abort_s),
      .dav_n_i     (dav_n_s),
      .data_i      (data_s),
      .rfd_o       (bus_rfd_out),
      .dac_o       (bus_dac_out),
      .rx_data_o   (rx_data),
      .rx_strobe_o (rx_strobe)
   );

   // R9: talker mode keeps the receiving lines released
   assert_talk_blocks_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (talk_mode && $past(talk_mode)) |-> (bus_rfd_out && bus_dac_out && !rx_strobe));

endmodule

// File: tb/byte_handshake_engine_bench.sv
`timescale 1ns/1ps
module hs_tb_acceptor #(
   parameter int DLY = 1
) (
   input  logic       clk,
   input  logic       en,
   input  logic       dav_n,
   input  logic [7:0] data,
   output logic       rfd,
   output logic       dac,
   output logic [7:0] last,
   output int         count
);
   int st  = 0;
   int cnt = 0;
   initial begin
      rfd = 1'b1; dac = 1'b1; last = 8'h00; count = 0;
   end
   always @(negedge clk) begin
      if (!en) begin
         rfd <= 1'b1; dac <= 1'b1; st <= 0; cnt <= 0;
      end else begin
         case (st)
            0: begin
               rfd <= 1'b1; dac <= 1'b0;
               if (!dav_n) begin
                  if (cnt >= DLY) begin
                     last <= data; count <= count + 1;
                     rfd <= 1'b0; dac <= 1'b1; st <= 1; cnt <= 0;
                  end else cnt <= cnt + 1;
               end
            end
            1: if (dav_n) begin dac <= 1'b0; st <= 2; end
            default: begin
               if (cnt >= DLY) begin rfd <= 1'b1; st <= 0; cnt <= 0; end
               else cnt <= cnt + 1;
            end
         endcase
      end
   end
endmodule

module byte_handshake_engine_bench;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       talk_mode = 0, listen_mode = 0, addr_mode = 0, abort_n = 1;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 0;
   logic       tx_ready, rx_strobe;
   logic [7:0] rx_data;
   logic [7:0] dut_data_o;
   logic       dut_oe, dut_dav_n_o, dut_rfd_o, dut_dac_o;

   logic [7:0] tb_data = 8'h00;
   logic       tb_drv = 0, tb_dav_n = 1;
   logic       a0_en = 0, a1_en = 0;
   logic       a0_rfd, a0_dac, a1_rfd, a1_dac;
   logic [7:0] a0_last, a1_last;
   int         a0_cnt, a1_cnt;

   logic [7:0] bus_data;
   logic       bus_dav_n, bus_rfd, bus_dac;
   assign bus_data  = dut_oe ? dut_data_o : (tb_drv ? tb_data : 8'hFF);
   assign bus_dav_n = dut_dav_n_o & tb_dav_n;
   assign bus_rfd   = dut_rfd_o & a0_rfd & a1_rfd;
   assign bus_dac   = dut_dac_o & a0_dac & a1_dac;

   byte_handshake_engine u_byte_handshake_engine (
      .clk(clk), .rst_n(rst_n), .talk_mode(talk_mode), .listen_mode(listen_mode),
      .addr_mode(addr_mode), .bus_abort_n(abort_n), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_strobe(rx_strobe),
      .bus_data_in(bus_data), .bus_data_out(dut_data_o), .bus_data_oe(dut_oe),
      .bus_dav_n_in(bus_dav_n), .bus_dav_n_out(dut_dav_n_o),
      .bus_rfd_in(bus_rfd), .bus_rfd_out(dut_rfd_o),
      .bus_dac_in(bus_dac), .bus_dac_out(dut_dac_o));

   hs_tb_acceptor #(.DLY(1)) u_acc_fast (.clk(clk), .en(a0_en), .dav_n(bus_dav_n),
      .data(bus_data), .rfd(a0_rfd), .dac(a0_dac), .last(a0_last), .count(a0_cnt));
   hs_tb_acceptor #(.DLY(6)) u_acc_slow (.clk(clk), .en(a1_en), .dav_n(bus_dav_n),
      .data(bus_data), .rfd(a1_rfd), .dac(a1_dac), .last(a1_last), .count(a1_cnt));

   int n_chk = 0, n_err = 0;
   int n_strobe = 0;
   int v_rfd = 0, v_rel = 0, v_stab = 0, v_idle = 0;
   logic mon_en = 0, idle_mon = 0;
   logic p_dav_n = 1, p_rfd = 0, p_oe = 0, p_davo = 1;
   logic [7:0] p_data = 8'h00;

   always @(negedge clk) begin
      #1;
      if (rst_n && rx_strobe) n_strobe++;
      if (mon_en) begin
         if (p_dav_n && !bus_dav_n && !p_rfd) v_rfd++;
         if (p_oe && !dut_oe && !p_davo) v_rel++;
         if (p_oe && dut_oe && dut_data_o != p_data) v_stab++;
      end
      if (idle_mon && (!dut_rfd_o || !dut_dac_o || rx_strobe)) v_idle++;
      p_dav_n = bus_dav_n; p_rfd = bus_rfd; p_oe = dut_oe;
      p_davo = dut_dav_n_o; p_data = dut_data_o;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_send(input logic [7:0] b, input string req);
      int w;
      @(negedge clk); tb_drv = 1; tb_data = b;
      w = 0;
      while (!(bus_rfd && !bus_dac) && w < 400) begin @(negedge clk); w++; end
      chk(w < 400, req, "ready wait", w, 0);
      tb_dav_n = 0;
      w = 0;
      while (!bus_dac && w < 400) begin @(negedge clk); w++; end
      chk(w < 400, req, "accepted wait", w, 0);
      tb_dav_n = 1;
      w = 0;
      while (bus_dac && w < 400) begin @(negedge clk); w++; end
      tb_drv = 0;
      cycles(4);
   endtask

   task automatic t_reset();
      rst_n = 0; cycles(5); rst_n = 1; cycles(1);
      chk(dut_dav_n_o == 1, "R1", "dav released", dut_dav_n_o, 1);
      chk(dut_oe == 0, "R1", "data enable", dut_oe, 0);
      chk(dut_rfd_o == 1 && dut_dac_o == 1, "R1", "rfd/dac released",
          {dut_rfd_o, dut_dac_o}, 3);
      chk(tx_ready == 0 && rx_strobe == 0, "R1", "ready/strobe", {tx_ready, rx_strobe}, 0);
   endtask

   task automatic t_source();
      logic [7:0] bytes [3];
      int w;
      bytes[0] = 8'hA5; bytes[1] = 8'h3C; bytes[2] = 8'h00;
      a0_en = 1; a1_en = 1; talk_mode = 1; mon_en = 1;
      cycles(4);
      chk(tx_ready == 1, "R2", "tx_ready in talker mode", tx_ready, 1);
      for (int i = 0; i < 3; i++) begin
         int c0, c1;
         c0 = a0_cnt; c1 = a1_cnt;
         w = 0;
         while (!tx_ready && w < 400) begin @(negedge clk); w++; end
         tx_data = bytes[i]; tx_valid = 1;
         @(negedge clk); tx_valid = 0;
         chk(dut_oe == 1 && dut_data_o == bytes[i] && dut_dav_n_o == 1, "R2",
             "byte driven before valid", dut_data_o, bytes[i]);
         w = 0;
         while (!(tx_ready && a1_cnt == c1 + 1 && a0_cnt == c0 + 1) && w < 400) begin
            @(negedge clk); w++;
         end
         chk(a0_last == bytes[i] && a0_cnt == c0 + 1, "R7", "fast receiver byte",
             a0_last, bytes[i]);
         chk(a1_last == bytes[i] && a1_cnt == c1 + 1, "R7", "slow receiver byte",
             a1_last, bytes[i]);
      end
      chk(dut_oe == 0 && dut_dav_n_o == 1, "R4", "lines released after transfer",
          {dut_oe, dut_dav_n_o}, 1);
      talk_mode = 0; a0_en = 0; a1_en = 0; cycles(4);
   endtask

   task automatic t_listen_latency();
      int w;
      listen_mode = 1; cycles(4);
      chk(dut_rfd_o == 1 && dut_dac_o == 0, "R5", "waiting lines", {dut_rfd_o, dut_dac_o}, 2);
      tb_drv = 1; tb_data = 8'h5A;
      @(negedge clk); tb_dav_n = 0;
      @(negedge clk);
      chk(rx_strobe == 0, "R11", "no strobe after 1 edge", rx_strobe, 0);
      @(negedge clk);
      chk(rx_strobe == 0, "R11", "no strobe after 2 edges", rx_strobe, 0);
      @(negedge clk);
      chk(rx_strobe == 1 && rx_data == 8'h5A, "R11", "strobe after 3 edges", rx_data, 8'h5A);
      chk(dut_rfd_o == 0 && dut_dac_o == 1, "R5", "accepted lines", {dut_rfd_o, dut_dac_o}, 1);
      @(negedge clk);
      chk(rx_strobe == 0, "R5", "strobe one cycle wide", rx_strobe, 0);
      cycles(5);
      chk(dut_dac_o == 1, "R6", "accepted held while valid low", dut_dac_o, 1);
      tb_dav_n = 1;
      w = 0;
      while (dut_dac_o && w < 50) begin @(negedge clk); w++; end
      chk(dut_dac_o == 0 && dut_rfd_o == 1, "R6", "ready again after valid high",
          {dut_rfd_o, dut_dac_o}, 2);
      tb_drv = 0; cycles(2);
   endtask

   task automatic t_listen_stream();
      int s0;
      a1_en = 1; mon_en = 1; cycles(2);
      s0 = n_strobe;
      bus_send(8'h11, "R7");
      chk(rx_data == 8'h11 && a1_last == 8'h11, "R7", "both receivers first byte", rx_data, 8'h11);
      bus_send(8'hFE, "R7");
      chk(rx_data == 8'hFE && a1_last == 8'hFE, "R7", "both receivers second byte", rx_data, 8'hFE);
      chk(n_strobe == s0 + 2, "R5", "one strobe per byte", n_strobe - s0, 2);
      a1_en = 0; listen_mode = 0; cycles(4);
   endtask

   task automatic t_addr_mode();
      int s0;
      addr_mode = 1; cycles(4);
      s0 = n_strobe;
      bus_send(8'h3F, "R8");
      chk(rx_data == 8'h3F && n_strobe == s0 + 1, "R8", "address-mode byte received",
          rx_data, 8'h3F);
      addr_mode = 0; cycles(4);
   endtask

   task automatic t_idle();
      int s0;
      a0_en = 1; cycles(4);
      s0 = n_strobe; v_idle = 0; idle_mon = 1;
      bus_send(8'h77, "R9");
      idle_mon = 0;
      chk(v_idle == 0, "R9", "idle lines released", v_idle, 0);
      chk(a0_last == 8'h77 && n_strobe == s0, "R9", "others transfer, no strobe", n_strobe - s0, 0);
      talk_mode = 1; listen_mode = 1; cycles(4);
      s0 = n_strobe; idle_mon = 1;
      bus_send(8'h12, "R9");
      idle_mon = 0;
      chk(v_idle == 0 && n_strobe == s0, "R9", "talker mode blocks receiving", v_idle, 0);
      talk_mode = 0; listen_mode = 0; a0_en = 0; cycles(4);
   endtask

   task automatic t_abort();
      int w;
      mon_en = 0;
      a0_en = 1; a1_en = 1; talk_mode = 1; cycles(4);
      tx_data = 8'hC3; tx_valid = 1;
      @(negedge clk); tx_valid = 0;
      w = 0;
      while (dut_dav_n_o && w < 100) begin @(negedge clk); w++; end
      chk(dut_dav_n_o == 0, "R10", "valid low before abort", dut_dav_n_o, 0);
      abort_n = 0;
      cycles(3);
      chk(dut_dav_n_o == 1 && dut_oe == 0, "R10", "sender idle after abort",
          {dut_dav_n_o, dut_oe}, 2);
      chk(tx_ready == 0, "R10", "no ready during abort", tx_ready, 0);
      abort_n = 1; talk_mode = 0; a0_en = 0; a1_en = 0; cycles(6);
      listen_mode = 1; cycles(4);
      tb_drv = 1; tb_data = 8'h66;
      @(negedge clk); tb_dav_n = 0;
      w = 0;
      while (!dut_dac_o && w < 50) begin @(negedge clk); w++; end
      abort_n = 0;
      cycles(3);
      chk(dut_rfd_o == 1 && dut_dac_o == 1, "R10", "receiver released after abort",
          {dut_rfd_o, dut_dac_o}, 3);
      tb_dav_n = 1; tb_drv = 0; abort_n = 1; listen_mode = 0; cycles(6);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_source();
      t_listen_latency();
      t_listen_stream();
      t_addr_mode();
      t_idle();
      t_abort();
      chk(v_rfd == 0, "R3", "valid fell with ready low", v_rfd, 0);
      chk(v_rel == 0, "R4", "data released before valid high", v_rel, 0);
      chk(v_stab == 0, "R4", "driven data changed", v_stab, 0);
      summary();
      $finish;
   end
endmodule